// File: doc/BRIEF.md
# Half-Rate 16-Bit to Byte-Stream Transmit Adapter

This block sits between a client that delivers transmit frames as 16-bit words and a MAC transmit engine that takes one byte per byte-clock cycle. The client runs at half the byte rate. It is modelled here as a clock enable, `cl_strobe`, which the block derives from the byte clock. The client samples the block's outputs and presents a new word on every cycle where `cl_strobe` is high. Each word is qualified by a word-valid and an upper-byte-valid. The block emits the low byte first and the high byte in the following byte cycle. It marks the final byte of each frame with an end-of-frame flag.

Each word is held for one half-rate cycle before it is emitted. This delay lets the block know whether the upper byte of the buffered word is the last byte of the frame. The control state machine has four states:
- `ST_IDLE`: waiting for a frame.
- `ST_BODY`: inside a frame whose last word was full.
- `ST_LAST`: the last word of an odd-length frame was sampled.
- `ST_FLUSH`: the frame was aborted and the rest of the client's words are being discarded.

The transitions are:
- Start: `ST_IDLE` goes to `ST_BODY` or `ST_LAST`.
- Continue: `ST_BODY` stays in `ST_BODY`.
- Odd tail: `ST_BODY` goes to `ST_LAST`.
- End: `ST_BODY` or `ST_LAST` goes to `ST_IDLE`.
- Abort: `ST_BODY` or `ST_LAST` goes to `ST_FLUSH` or `ST_IDLE`.
- Drain: `ST_FLUSH` goes to `ST_IDLE`.

Top module: `tx16to8_adapter`

## Requirements
- R1: `cl_strobe` is high in the first byte cycle after reset and then toggles every byte cycle. Client inputs are sampled only on the clock edge that ends a cycle where `cl_strobe` is high.
- R2: A word sampled at one strobe edge appears on `tx_byte` starting at the next strobe edge. Bits 7:0 appear first and bits 15:8 appear in the following byte cycle, each with `tx_vld` high.
- R3: In a frame with an even byte count, both valids are high for every word. `tx_eof` is high together with the high byte of the last word.
- R4: A word with `cl_wvld`=1 and `cl_hvld`=0 is the final word of an odd-length frame. Its low byte carries `tx_eof`=1. Its high-byte slot has `tx_vld`=0, so the high byte is discarded.
- R5: One sampled word with both valids low between frames produces exactly two idle byte slots after an even frame. After an odd frame it produces three idle slots, because the discarded upper slot adds one.
- R6: `cl_ack` rises in the same byte cycle as the first byte of each frame appears on `tx_byte`. It stays high for exactly two byte cycles, which is one half-rate cycle.
- R7: If `cl_underrun` is sampled high inside a frame, the buffered word is discarded and no `tx_eof` is produced. `tx_bad` pulses for one byte cycle with `tx_vld` low in that cycle and the next. Further words are ignored until `cl_wvld` is sampled low.
- R8: Sampling `cl_wvld`=0 with `cl_hvld`=1 inside a frame is a protocol error and is treated exactly as in R7. A word with `cl_wvld`=1 sampled directly after an odd final word is also treated as in R7.
- R9: In `ST_IDLE`, `cl_hvld` and `cl_underrun` have no effect while `cl_wvld` is low. No byte, acknowledge or bad flag results.
- R10: While `rst_n` is low, `tx_vld`, `tx_eof`, `tx_bad` and `cl_ack` are all low.
- R11: `tx_eof` is never high without `tx_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_data | input | 2*BYTE_W | Client word, low byte in bits 7:0 |
| cl_wvld | input | 1 | Client word valid |
| cl_hvld | input | 1 | Client upper-byte valid |
| cl_underrun | input | 1 | Client request to abort the current frame |
| cl_strobe | output | 1 | Half-rate sample enable for the client |
| cl_ack | output | 1 | Frame acknowledge, one half-rate cycle long |
| tx_byte | output | BYTE_W | Byte to the transmit engine |
| tx_vld | output | 1 | `tx_byte` is a frame byte |
| tx_eof | output | 1 | Last byte of the frame |
| tx_bad | output | 1 | Current frame aborted |

## Verification
The bench sends frames of every length from one to nine bytes back to back. It checks each byte, the placement of every end-of-frame flag, and the idle count between frames. A design that emitted the high byte first would fail the byte comparisons. A design that kept or flagged the wrong byte of an odd final word would misplace `tx_eof` or insert a stray byte. A design without the one-word hold would flag the end one byte late or shrink the two-slot gap. Underrun and protocol-error frames are followed by a normal frame, which exposes any leaked byte, missing bad pulse or stuck state. An idle burst with the upper valid and underrun high shows whether idle inputs leak through.

// File: rtl/tx16to8_pkg.sv
package tx16to8_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_LAST,
        ST_FLUSH
    } tx_st_e;
endpackage

// File: rtl/tx16to8_phase.sv
module tx16to8_phase (
    input  logic clk,
    input  logic rst_n,
    output logic strb
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign strb = ~phase_q;

    // R1
    strobe_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> !strb);
    // R1
    strobe_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |=> strb);
endmodule

// File: rtl/tx16to8_ctrl.sv
module tx16to8_ctrl
    import tx16to8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    input  logic wv,
    input  logic hv,
    input  logic ur,
    output logic take,
    output logic first,
    output logic abort
);
    tx_st_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)    st <= ST_IDLE;
        else if (strb) st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (wv) st_nxt = hv ? ST_BODY : ST_LAST;
            ST_BODY: begin
                if (ur)      st_nxt = wv ? ST_FLUSH : ST_IDLE;
                else if (wv) st_nxt = hv ? ST_BODY : ST_LAST;
                else         st_nxt = ST_IDLE;
            end
            ST_LAST:  st_nxt = wv ? ST_FLUSH : ST_IDLE;
            ST_FLUSH: st_nxt = wv ? ST_FLUSH : ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        take  = 1'b0;
        first = 1'b0;
        abort = 1'b0;
        if (strb) begin
            unique case (st)
                ST_IDLE: begin
                    take  = wv;
                    first = wv;
                end
                ST_BODY: begin
                    if (ur)      abort = 1'b1;
                    else if (wv) take  = 1'b1;
                    else if (hv) abort = 1'b1;
                end
                ST_LAST:  abort = ur | wv;
                ST_FLUSH: ;
                default:  ;
            endcase
        end
    end

    // R7
    abort_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (st == ST_IDLE || st == ST_FLUSH));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && st == ST_IDLE && !wv) |=> st == ST_IDLE);
endmodule

// File: rtl/tx16to8_ser.sv
module tx16to8_ser #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strb,
    input  logic                take,
    input  logic                first,
    input  logic                abort,
    input  logic                hv,
    input  logic [2*BYTE_W-1:0] din,
    output logic [BYTE_W-1:0]   out_byte,
    output logic                out_vld,
    output logic                out_eof,
    output logic                out_bad,
    output logic                ack
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] pend_d;
    logic              pend_v, pend_hv, pend_first;
    logic [BYTE_W-1:0] hi_d;
    logic              hi_v, hi_eof;
    logic              emit;

    assign emit = pend_v & ~abort;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_d     <= '0;
            pend_v     <= 1'b0;
            pend_hv    <= 1'b0;
            pend_first <= 1'b0;
            hi_d       <= '0;
            hi_v       <= 1'b0;
            hi_eof     <= 1'b0;
            out_byte   <= '0;
            out_vld    <= 1'b0;
            out_eof    <= 1'b0;
            out_bad    <= 1'b0;
            ack        <= 1'b0;
        end else if (strb) begin
            out_byte   <= pend_d[BYTE_W-1:0];
            out_vld    <= emit;
            out_eof    <= emit & ~pend_hv;
            out_bad    <= abort;
            ack        <= emit & pend_first;
            hi_d       <= pend_d[WORD_W-1:BYTE_W];
            hi_v       <= emit & pend_hv;
            hi_eof     <= emit & pend_hv & ~take;
            pend_d     <= din;
            pend_v     <= take;
            pend_hv    <= hv;
            pend_first <= first;
        end else begin
            out_byte   <= hi_d;
            out_vld    <= hi_v;
            out_eof    <= hi_eof;
            out_bad    <= 1'b0;
        end
    end

    // R11
    eof_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_vld);
    // R7
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> !out_vld);
    // R7
    bad_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |=> (!out_vld && !out_bad));
    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |=> ack);
    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |=> !ack);
endmodule

// File: rtl/tx16to8_adapter.sv
module tx16to8_adapter #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BYTE_W-1:0] cl_data,
    input  logic                cl_wvld,
    input  logic                cl_hvld,
    input  logic                cl_underrun,
    output logic                cl_strobe,
    output logic                cl_ack,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic                tx_vld,
    output logic                tx_eof,
    output logic                tx_bad
);
    logic take, first, abort;

    tx16to8_phase u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .strb (cl_strobe)
    );

    tx16to8_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .strb (cl_strobe),
        .wv   (cl_wvld),
        .hv   (cl_hvld),
        .ur   (cl_underrun),
        .take (take),
        .first(first),
        .abort(abort)
    );

    tx16to8_ser #(.BYTE_W(BYTE_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (cl_strobe),
        .take    (take),
        .first   (first),
        .abort   (abort),
        .hv      (cl_hvld),
        .din     (cl_data),
        .out_byte(tx_byte),
        .out_vld (tx_vld),
        .out_eof (tx_eof),
        .out_bad (tx_bad),
        .ack     (cl_ack)
    );
endmodule

// File: tb/sim_tx16to8_adapter.sv
module sim_tx16to8_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cl_data = '0;
    logic        cl_wvld = 1'b0, cl_hvld = 1'b0, cl_underrun = 1'b0;
    logic        cl_strobe, cl_ack, tx_vld, tx_eof, tx_bad;
    logic [7:0]  tx_byte;

    always #4 clk = ~clk;

    tx16to8_adapter #(.BYTE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cl_data(cl_data), .cl_wvld(cl_wvld),
        .cl_hvld(cl_hvld), .cl_underrun(cl_underrun), .cl_strobe(cl_strobe),
        .cl_ack(cl_ack), .tx_byte(tx_byte), .tx_vld(tx_vld),
        .tx_eof(tx_eof), .tx_bad(tx_bad)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] cap_b [0:511];
    logic       cap_e [0:511];
    int gaps [0:63];
    int cap_n = 0, gap_n = 0, eof_n = 0, bad_n = 0;
    int ack_cyc = 0, ack_rise = 0, idle = 100;
    logic ack_q = 1'b0, in_frm = 1'b0, ended = 1'b0;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int f, input int i);
        return 8'((f * 37 + i * 11 + 3) & 255);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 30000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (cl_ack) ack_cyc++;
            if (cl_ack && !ack_q) ack_rise++;
            ack_q = cl_ack;
            if (tx_bad) begin
                bad_n++;
                in_frm = 1'b0;
            end
            if (tx_vld) begin
                if (!in_frm) begin
                    // R6: ack accompanies the first byte
                    chk(cl_ack == 1'b1, "R6 ack at first byte", int'(cl_ack), 1);
                    if (ended && idle < 8) begin
                        gaps[gap_n] = idle;
                        gap_n++;
                    end
                    ended  = 1'b0;
                    in_frm = 1'b1;
                end
                cap_b[cap_n] = tx_byte;
                cap_e[cap_n] = tx_eof;
                cap_n++;
                idle = 0;
                if (tx_eof) begin
                    ended  = 1'b1;
                    in_frm = 1'b0;
                    eof_n++;
                end
            end else begin
                idle++;
            end
        end
    end

    task automatic put_word(input logic wv, input logic hv, input logic ur, input logic [15:0] d);
        @(negedge clk);
        while (!cl_strobe) @(negedge clk);
        cl_wvld = wv;
        cl_hvld = hv;
        cl_underrun = ur;
        cl_data = d;
    endtask

    task automatic send_frame(input int f, input int len);
        for (int w = 0; w < (len + 1) / 2; w++) begin
            logic hv;
            hv = (2 * w + 1 < len);
            put_word(1'b1, hv, 1'b0, {hv ? bval(f, 2 * w + 1) : 8'hEE, bval(f, 2 * w)});
        end
        put_word(1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic idle_words(input int n);
        for (int k = 0; k < n; k++) put_word(1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        int b, g, k, e0, b0, a0;
        repeat (4) @(negedge clk);
        // R10: outputs quiet in reset
        chk(!tx_vld && !tx_eof && !tx_bad && !cl_ack, "R10 reset outputs",
            int'({tx_vld, tx_eof, tx_bad, cl_ack}), 0);
        rst_n = 1'b1;
        // R1: strobe high first, then alternating
        for (int i = 0; i < 6; i++) begin
            chk(cl_strobe == ((i % 2) == 0), "R1 strobe pattern", int'(cl_strobe), int'((i % 2) == 0));
            @(negedge clk);
        end

        // R2 R3 R4 R5: back-to-back sweep of lengths 1..9
        b = cap_n;
        g = gap_n;
        for (int f = 0; f < 9; f++) send_frame(f, f + 1);
        idle_words(6);
        chk(cap_n - b == 45, "R2 byte count of sweep", cap_n - b, 45);
        k = b;
        for (int f = 0; f < 9; f++) begin
            for (int i = 0; i <= f; i++) begin
                chk(cap_b[k] == bval(f, i), "R2 byte order", int'(cap_b[k]), int'(bval(f, i)));
                if ((f % 2) == 1)
                    chk(cap_e[k] == (i == f), "R3 even frame eof", int'(cap_e[k]), int'(i == f));
                else
                    chk(cap_e[k] == (i == f), "R4 odd frame eof", int'(cap_e[k]), int'(i == f));
                k++;
            end
        end
        chk(gap_n - g == 8, "R5 gap count", gap_n - g, 8);
        for (int f = 0; f < 8; f++)
            chk(gaps[g + f] == (((f + 1) % 2 == 1) ? 3 : 2), "R5 idle slots",
                gaps[g + f], ((f + 1) % 2 == 1) ? 3 : 2);
        chk(bad_n == 0, "R7 no bad in clean frames", bad_n, 0);

        // R7: underrun on third word
        b = cap_n;
        e0 = eof_n;
        b0 = bad_n;
        put_word(1'b1, 1'b1, 1'b0, {bval(20, 1), bval(20, 0)});
        put_word(1'b1, 1'b1, 1'b0, {bval(20, 3), bval(20, 2)});
        put_word(1'b1, 1'b1, 1'b1, {bval(20, 5), bval(20, 4)});
        put_word(1'b1, 1'b1, 1'b0, {bval(20, 7), bval(20, 6)});
        idle_words(4);
        chk(cap_n - b == 2, "R7 bytes before underrun", cap_n - b, 2);
        chk(cap_b[b] == bval(20, 0) && cap_b[b + 1] == bval(20, 1), "R7 surviving bytes",
            int'(cap_b[b + 1]), int'(bval(20, 1)));
        chk(eof_n == e0, "R7 no eof on abort", eof_n - e0, 0);
        chk(bad_n - b0 == 1, "R7 bad pulse", bad_n - b0, 1);
        b = cap_n;
        send_frame(21, 4);
        idle_words(4);
        chk(cap_n - b == 4 && cap_e[b + 3] && cap_b[b + 3] == bval(21, 3), "R7 recovery frame",
            cap_n - b, 4);

        // R8: word valid drops with upper valid high
        b = cap_n;
        e0 = eof_n;
        b0 = bad_n;
        put_word(1'b1, 1'b1, 1'b0, {bval(30, 1), bval(30, 0)});
        put_word(1'b1, 1'b1, 1'b0, {bval(30, 3), bval(30, 2)});
        put_word(1'b0, 1'b1, 1'b0, 16'h0);
        idle_words(4);
        chk(cap_n - b == 2, "R8 bytes before error", cap_n - b, 2);
        chk(eof_n == e0, "R8 no eof on error", eof_n - e0, 0);
        chk(bad_n - b0 == 1, "R8 bad pulse", bad_n - b0, 1);
        b = cap_n;
        send_frame(31, 3);
        idle_words(4);
        chk(cap_n - b == 3 && cap_e[b + 2] && cap_b[b + 2] == bval(31, 2), "R8 recovery frame",
            cap_n - b, 3);

        // R9: idle with upper valid and underrun high
        b = cap_n;
        b0 = bad_n;
        a0 = ack_rise;
        for (int i = 0; i < 3; i++) put_word(1'b0, 1'b1, 1'b1, 16'hA5A5);
        idle_words(4);
        chk(cap_n == b, "R9 no bytes in idle", cap_n - b, 0);
        chk(bad_n == b0, "R9 no bad in idle", bad_n - b0, 0);
        chk(ack_rise == a0, "R9 no ack in idle", ack_rise - a0, 0);

        // R6: one ack per started frame, two byte cycles each
        chk(ack_rise == 13, "R6 ack count", ack_rise, 13);
        chk(ack_cyc == 26, "R6 ack width", ack_cyc, 26);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule